// File: doc/BRIEF.md
# Dual-Slope Measurement Phase Sequencer

This block steps an external integrator through one impedance measurement. After reset it stays idle for a power-on wait. It then runs a display-test phase and spends one clock applying default settings. From there it loops over measurement cycles without further prompting. Each cycle runs offset null, a first and a second phase-alignment period, a charge period of fixed length, and a discharge period. A hold period comes after every phase, so that switching transients can settle and the integrator capacitor can empty.

Every phase has its own control strobe. All phase lengths except discharge are counted in ticks of a system clock enable. During discharge the block counts ticks of a separate measurement clock enable until the zero-crossing flag arrives. It then freezes that count as the result and pulses a valid flag. Results alternate between the primary reading (inductance, capacitance or resistance) and the loss-factor reading, and the primary reading comes first. A saturation flag sampled when offset null ends cuts the cycle short and raises a range-shift request. This lets range search move faster.

Top module: `meas_seq`

## Requirements
- R1: While reset is held, every strobe, `result_valid`, `timeout`, `range_req` and `meas_kind` are 0 and `count` is 0.
- R2: After reset, no phase strobe is asserted until PWR_TICKS ticks of `tick_en` have passed.
- R3: `disp_test` is then high for DTEST_TICKS ticks. After it, `load_defaults` is high for exactly one clock and sets `meas_kind` to 0 (primary reading).
- R4: A cycle asserts `null_en`, `apa1_en`, `apa2_en`, `charge_en` and `discharge_en` in that order, and never more than one of them at a time.
- R5: After each phase, including discharge and an aborted offset null, `hold_en` is high for HOLD_TICKS ticks of `tick_en` before the next phase starts.
- R6: Offset null, the two phase-alignment periods and charge last NULL_TICKS, APA1_TICKS, APA2_TICKS and CHG_TICKS ticks of `tick_en` respectively. `meas_tick` and `zero_in` have no effect on them.
- R7: During discharge the counter starts at 0 and adds one for each clock in which `meas_tick` is high. When `zero_in` is high, the count is frozen onto `count`, `result_valid` pulses for one clock, and `timeout` is 0.
- R8: If `meas_tick` is high while the count already equals 2**CNT_W-1 and `zero_in` is low, discharge ends. `count` then reads 2**CNT_W-1, `timeout` is 1 and `result_valid` pulses.
- R9: `sat_in` is sampled only in the clock that ends offset null. If it is high there, `range_req` pulses for one clock, a hold follows, and offset null restarts with no result and no change to `meas_kind`.
- R10: `meas_kind` flips in the same clock that `result_valid` goes high, and the next cycle begins with no outside request.
- R11: When `zero_in` and `meas_tick` are both high in the same discharge clock, `zero_in` wins. The count is frozen without the extra increment, even at the maximum count, and `timeout` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Clock enable that times the fixed phases |
| meas_tick | input | 1 | Clock enable counted during discharge |
| sat_in | input | 1 | Saturation flag from the detector |
| zero_in | input | 1 | Integrator zero-crossing flag |
| disp_test | output | 1 | Display-test phase active |
| load_defaults | output | 1 | One-clock default-settings strobe |
| null_en | output | 1 | Offset-null phase strobe |
| apa1_en | output | 1 | First phase-alignment strobe |
| apa2_en | output | 1 | Second phase-alignment strobe |
| charge_en | output | 1 | Integrator charge strobe |
| discharge_en | output | 1 | Integrator discharge strobe |
| hold_en | output | 1 | Hold between phases |
| meas_kind | output | 1 | 0 = primary reading, 1 = loss-factor reading |
| result_valid | output | 1 | One-clock pulse when a new count is frozen |
| timeout | output | 1 | Last result ended at the count limit |
| range_req | output | 1 | One-clock range-shift request |
| count | output | CNT_W | Last frozen discharge count |

## Verification
Several decisions can land in the same discharge clock. A zero crossing can arrive together with a measurement tick, and in one cycle it does so exactly when the counter sits at its maximum, so that the zero-crossing path and the timeout path compete. The bench forces that case, and also lets the two flags coincide at random in later cycles. A saturation flag held high across offset null is judged at the clock that ends the phase, while toggles at other times must leave the sequence alone. Every output is compared on every clock against a behavioural model.

// File: rtl/meas_seq.sv
module meas_seq #(
  parameter int PWR_TICKS   = 300,
  parameter int DTEST_TICKS = 100,
  parameter int NULL_TICKS  = 16,
  parameter int APA1_TICKS  = 8,
  parameter int APA2_TICKS  = 8,
  parameter int CHG_TICKS   = 64,
  parameter int HOLD_TICKS  = 4,
  parameter int CNT_W       = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             meas_tick,
  input  logic             sat_in,
  input  logic             zero_in,
  output logic             disp_test,
  output logic             load_defaults,
  output logic             null_en,
  output logic             apa1_en,
  output logic             apa2_en,
  output logic             charge_en,
  output logic             discharge_en,
  output logic             hold_en,
  output logic             meas_kind,
  output logic             result_valid,
  output logic             timeout,
  output logic             range_req,
  output logic [CNT_W-1:0] count
);
  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int LMAX = imax(imax(imax(PWR_TICKS, DTEST_TICKS), imax(NULL_TICKS, APA1_TICKS)),
                             imax(imax(APA2_TICKS, CHG_TICKS), HOLD_TICKS));
  localparam int TW = $clog2(LMAX + 1);
  localparam logic [CNT_W-1:0] CMAX = '1;

  typedef enum logic [3:0] {
    S_PWR, S_DTEST, S_INIT, S_NULL, S_APA1, S_APA2, S_CHG, S_DIS, S_HOLD
  } st_t;

  st_t st, after;
  logic [TW-1:0] tmr, last;
  logic [CNT_W-1:0] dcnt;

  always_comb begin
    case (st)
      S_PWR:   last = TW'(PWR_TICKS - 1);
      S_DTEST: last = TW'(DTEST_TICKS - 1);
      S_NULL:  last = TW'(NULL_TICKS - 1);
      S_APA1:  last = TW'(APA1_TICKS - 1);
      S_APA2:  last = TW'(APA2_TICKS - 1);
      S_CHG:   last = TW'(CHG_TICKS - 1);
      default: last = TW'(HOLD_TICKS - 1);
    endcase
  end

  assign disp_test     = (st == S_DTEST);
  assign load_defaults = (st == S_INIT);
  assign null_en       = (st == S_NULL);
  assign apa1_en       = (st == S_APA1);
  assign apa2_en       = (st == S_APA2);
  assign charge_en     = (st == S_CHG);
  assign discharge_en  = (st == S_DIS);
  assign hold_en       = (st == S_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_PWR;
      after        <= S_NULL;
      tmr          <= '0;
      dcnt         <= '0;
      count        <= '0;
      timeout      <= 1'b0;
      result_valid <= 1'b0;
      range_req    <= 1'b0;
      meas_kind    <= 1'b0;
    end else begin
      result_valid <= 1'b0;
      range_req    <= 1'b0;
      case (st)
        S_INIT: begin
          st        <= S_NULL;
          meas_kind <= 1'b0;
        end
        S_DIS: begin
          if (zero_in || (meas_tick && dcnt == CMAX)) begin
            count        <= dcnt;
            timeout      <= !zero_in;
            result_valid <= 1'b1;
            meas_kind    <= ~meas_kind;
            st           <= S_HOLD;
            after        <= S_NULL;
          end else if (meas_tick) begin
            dcnt <= dcnt + 1'b1;
          end
        end
        default: begin
          if (tick_en) begin
            if (tmr == last) begin
              tmr <= '0;
              case (st)
                S_PWR:   st <= S_DTEST;
                S_DTEST: st <= S_INIT;
                S_NULL: begin
                  st        <= S_HOLD;
                  after     <= sat_in ? S_NULL : S_APA1;
                  range_req <= sat_in;
                end
                S_APA1: begin st <= S_HOLD; after <= S_APA2; end
                S_APA2: begin st <= S_HOLD; after <= S_CHG; end
                S_CHG: begin
                  st    <= S_HOLD;
                  after <= S_DIS;
                  dcnt  <= '0;
                end
                S_HOLD:  st <= after;
                default: st <= S_PWR;
              endcase
            end else begin
              tmr <= tmr + 1'b1;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/meas_seq_chk.sv
module meas_seq_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             meas_tick,
  input logic             zero_in,
  input logic             null_en,
  input logic             apa1_en,
  input logic             apa2_en,
  input logic             charge_en,
  input logic             discharge_en,
  input logic             hold_en,
  input logic             meas_kind,
  input logic             result_valid,
  input logic             timeout,
  input logic             range_req,
  input logic [CNT_W-1:0] count
);
  // R4
  one_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({null_en, apa1_en, apa2_en, charge_en, discharge_en, hold_en}));

  // R5
  hold_before_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(discharge_en) |-> $past(hold_en));

  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);

  // R7
  valid_after_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> ($past(discharge_en) && hold_en));

  // R8
  timeout_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> (count == {CNT_W{1'b1}}));

  // R9
  range_after_null_chk: assert property (@(posedge clk) disable iff (!rst_n)
    range_req |-> ($past(null_en) && hold_en && !result_valid));

  // R10
  kind_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> (meas_kind != $past(meas_kind)));

  // R11
  zero_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (discharge_en && zero_in && meas_tick) |=> (result_valid && !timeout));
endmodule

bind meas_seq meas_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .meas_tick(meas_tick), .zero_in(zero_in),
  .null_en(null_en), .apa1_en(apa1_en), .apa2_en(apa2_en),
  .charge_en(charge_en), .discharge_en(discharge_en), .hold_en(hold_en),
  .meas_kind(meas_kind), .result_valid(result_valid), .timeout(timeout),
  .range_req(range_req), .count(count)
);

// File: tb/meas_seq_tb.sv
module meas_seq_tb;
  localparam int PW = 5, DT = 3, NL = 4, A1 = 3, A2 = 2, CH = 6, HL = 2, CW = 6;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 0, rst_n = 0;
  logic tick_en = 0, meas_tick = 0, sat_in = 0, zero_in = 0;
  logic disp_test, load_defaults, null_en, apa1_en, apa2_en, charge_en;
  logic discharge_en, hold_en, meas_kind, result_valid, timeout, range_req;
  logic [CW-1:0] count;

  always #5 clk = ~clk;

  meas_seq #(.PWR_TICKS(PW), .DTEST_TICKS(DT), .NULL_TICKS(NL), .APA1_TICKS(A1),
             .APA2_TICKS(A2), .CHG_TICKS(CH), .HOLD_TICKS(HL), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .meas_tick(meas_tick),
    .sat_in(sat_in), .zero_in(zero_in), .disp_test(disp_test),
    .load_defaults(load_defaults), .null_en(null_en), .apa1_en(apa1_en),
    .apa2_en(apa2_en), .charge_en(charge_en), .discharge_en(discharge_en),
    .hold_en(hold_en), .meas_kind(meas_kind), .result_valid(result_valid),
    .timeout(timeout), .range_req(range_req), .count(count));

  // behavioural reference: 0 pwr,1 dtest,2 init,3 null,4 apa1,5 apa2,6 chg,7 dis,8 hold
  integer ph, nxt, tc, dc, m_res, m_to, m_val, m_rr, m_kind, ncyc;
  integer checks = 0, fails = 0;

  function automatic integer plen(input integer p);
    case (p)
      0: plen = PW; 1: plen = DT; 3: plen = NL; 4: plen = A1;
      5: plen = A2; 6: plen = CH; default: plen = HL;
    endcase
  endfunction

  task automatic finish_dis();
    m_val = 1; m_kind = 1 - m_kind; nxt = 3; ph = 8;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; nxt = 3; tc = 0; dc = 0; m_res = 0; m_to = 0;
      m_val = 0; m_rr = 0; m_kind = 0; ncyc = 0;
    end else begin
      m_val = 0; m_rr = 0;
      if (ph == 2) begin
        ph = 3; m_kind = 0; ncyc = ncyc + 1;
      end else if (ph == 7) begin
        if (zero_in) begin
          m_res = dc; m_to = 0; finish_dis();
        end else if (meas_tick) begin
          if (dc == MAXC) begin m_res = MAXC; m_to = 1; finish_dis(); end
          else dc = dc + 1;
        end
      end else if (tick_en) begin
        if (tc + 1 < plen(ph)) tc = tc + 1;
        else begin
          tc = 0;
          case (ph)
            0: ph = 1;
            1: ph = 2;
            3: begin nxt = sat_in ? 3 : 4; m_rr = sat_in ? 1 : 0; ph = 8; end
            4: begin nxt = 5; ph = 8; end
            5: begin nxt = 6; ph = 8; end
            6: begin nxt = 7; ph = 8; end
            default: begin
              ph = nxt;
              if (ph == 3) ncyc = ncyc + 1;
              if (ph == 7) dc = 0;
            end
          endcase
        end
      end
    end
  end

  task automatic cmp(input string tag, input integer act, input integer exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    cmp(ph == 0 ? "R2 disp_test" : "R3 disp_test", disp_test, ph == 1);
    cmp("R3 load_defaults", load_defaults, ph == 2);
    cmp(ph == 0 ? "R2 null_en" : "R4 null_en", null_en, ph == 3);
    cmp("R4 apa1_en", apa1_en, ph == 4);
    cmp("R6 apa2_en", apa2_en, ph == 5);
    cmp("R6 charge_en", charge_en, ph == 6);
    cmp("R4 discharge_en", discharge_en, ph == 7);
    cmp("R5 hold_en", hold_en, ph == 8);
    cmp("R10 meas_kind", meas_kind, m_kind);
    cmp(ncyc == 5 ? "R11 count" : "R7 count", count, m_res);
    cmp(ncyc == 5 ? "R11 timeout" : "R8 timeout", timeout, m_to);
    cmp("R7 result_valid", result_valid, m_val);
    cmp("R9 range_req", range_req, m_rr);
  endtask

  function automatic integer target(input integer c);
    case (c)
      1: target = 5;
      3: target = 0;
      4: target = 100000;
      5: target = MAXC;
      default: target = (c * 7) % 40;
    endcase
  endfunction

  initial begin : main
    logic [15:0] lf;
    integer cyc;
    lf = 16'hACE1;
    cyc = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    cmp("R1 strobes", {disp_test, load_defaults, null_en, apa1_en, apa2_en,
                       charge_en, discharge_en, hold_en}, 0);
    cmp("R1 flags", {meas_kind, result_valid, timeout, range_req}, 0);
    cmp("R1 count", count, 0);
    rst_n = 1;
    while (ncyc < 13) begin
      @(negedge clk);
      compare_all();
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      tick_en   = lf[0] | lf[3];
      meas_tick = lf[1] | lf[5];
      if (ph == 3) sat_in = (ncyc == 2 || ncyc == 7);
      else sat_in = lf[2];
      if (ph == 7) begin
        zero_in = (dc >= target(ncyc));
        if (ncyc == 5 && dc == MAXC) meas_tick = 1;
      end else zero_in = lf[4];
      cyc++;
      if (cyc >= 150000) begin
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=13", ncyc);
        break;
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule